// File: doc/BRIEF.md
# Rectangular Video Frame Receiver

This block sits at the input of a video pipeline. It takes 24-bit RGB pixels from an AXI4-Stream video slave port, where one packet carries one line (TLAST on the last pixel of the line) and TUSER[0] marks the first pixel of a frame. It turns that stream into frames of a fixed shape. The shape comes only from two configuration inputs, a row count and a column count, and never from the stream. Downstream stages can then rely on every frame holding exactly rows × cols pixels, flagged with frame-start and line-end markers on a valid/ready output.

At the start of a video sequence, or after an upstream glitch, lines can be short or long and frames can be cut off. The receiver repairs these cases. It discards pixels until a frame start is seen. It pads short lines and cut-off frames with zero pixels. It drops surplus pixels in long lines. A new frame start that arrives in the middle of a frame closes the current frame at once. Frame size is sampled when each frame starts, so changes to the configuration only take effect at frame boundaries.

Top module: `vfrx_frame_rx`

## Requirements
- R1: After reset, `m_valid` is low and `s_tready` is high while `m_ready` is high.
- R2: Input beats are accepted and discarded until a beat with `s_tuser`=1 arrives. The same applies to beats without `s_tuser` that arrive once a frame is complete.
- R3: Every output frame holds exactly `cfg_rows` × `cfg_cols` pixels. `m_sof` is set on the first pixel only, and `m_eol` is set on every `cfg_cols`-th pixel. A frame-start handshake only ever follows a line-end handshake.
- R4: Pixel words pass through unchanged. Green is bits [7:0], blue is bits [15:8] and red is bits [23:16].
- R5: A line whose TLAST comes before the `cfg_cols`-th pixel is completed with zero pixels. `s_tready` is low while this padding is emitted.
- R6: Pixels that follow the `cfg_cols`-th pixel of a line are accepted and discarded, up to and including the beat that carries TLAST.
- R7: A beat with `s_tuser`=1 that arrives inside a frame is held (`s_tready` low) while the rest of the frame is emitted as zeros. That beat then becomes the first pixel of the next frame.
- R8: `cfg_rows` and `cfg_cols` are sampled on the accepted frame-start beat. Changes made while a frame is in progress do not alter that frame.
- R9: While `m_valid` is high and `m_ready` is low, the output word and its flags are held, and `s_tready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | DIM_W | Lines per frame (at least 1) |
| cfg_cols | input | DIM_W | Pixels per line (at least 1) |
| s_tdata | input | PIX_W | Input pixel, {R,B,G} |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tlast | input | 1 | Last pixel of an input line |
| s_tuser | input | 1 | First pixel of an input frame |
| m_data | output | PIX_W | Output pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_sof | output | 1 | Output pixel is the first of a frame |
| m_eol | output | 1 | Output pixel is the last of a line |

## Verification
The bench uses the default widths (24-bit pixels, 12-bit dimensions) and programs tiny frames: two lines of three pixels, then one line of two. With frames this small, the test can pass through every repair path within a few dozen beats: a short line, a long line, a frame cut off by an early frame start, and stray beats between frames. It also reaches the case where a line ends on the very pixel that starts the frame. A mid-frame change of the column count is applied and checked against the value sampled at the frame start. Alternating and held-low output ready then exercise the stall paths.

// File: rtl/vfrx_pkg.sv
package vfrx_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 3;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_PIX,
    ACT_PAD,
    ACT_DROP
  } vfrx_act_e;
endpackage

// File: rtl/vfrx_pos.sv
module vfrx_pos #(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             start,
  input  logic [DIM_W-1:0] cfg_rows,
  input  logic [DIM_W-1:0] cfg_cols,
  output logic             at_org,
  output logic             line_end,
  output logic             frame_end
);
  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic [DIM_W-1:0] row_q, col_q, rows_q, cols_q;
  logic [DIM_W-1:0] eff_rows, eff_cols;

  assign at_org    = (row_q == '0) && (col_q == '0);
  assign eff_rows  = at_org ? cfg_rows : rows_q;
  assign eff_cols  = at_org ? cfg_cols : cols_q;
  assign line_end  = (col_q == eff_cols - ONE);
  assign frame_end = line_end && (row_q == eff_rows - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      rows_q <= ONE;
      cols_q <= ONE;
    end else begin
      if (start) begin
        rows_q <= cfg_rows;
        cols_q <= cfg_cols;
      end
      if (step) begin
        col_q <= line_end ? '0 : col_q + ONE;
        if (line_end) row_q <= frame_end ? '0 : row_q + ONE;
      end
    end
  end
endmodule

// File: rtl/vfrx_oreg.sv
module vfrx_oreg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_data,
  input  logic         d_sof,
  input  logic         d_eol,
  input  logic         m_ready,
  output logic         m_valid,
  output logic [W-1:0] m_data,
  output logic         m_sof,
  output logic         m_eol,
  output logic         free
);
  assign free = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_sof   <= 1'b0;
      m_eol   <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= d_data;
      m_sof   <= d_sof;
      m_eol   <= d_eol;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vfrx_frame_rx.sv
module vfrx_frame_rx
  import vfrx_pkg::*;
#(
  parameter int PIX_W = LANE_W * LANES,
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_rows,
  input  logic [DIM_W-1:0] cfg_cols,
  input  logic [PIX_W-1:0] s_tdata,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic             s_tlast,
  input  logic             s_tuser,
  output logic [PIX_W-1:0] m_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_sof,
  output logic             m_eol
);
  vfrx_act_e  act;
  logic       free, start, load;
  logic       at_org, line_end, frame_end;
  logic       pad_line_q, discard_q;
  logic [PIX_W-1:0] d_data;

  always_comb begin
    act      = ACT_IDLE;
    s_tready = 1'b0;
    start    = 1'b0;
    if (pad_line_q) begin
      if (free) act = ACT_PAD;
    end else begin
      s_tready = free;
      if (s_tvalid) begin
        if (s_tuser && !at_org) begin
          s_tready = 1'b0;
          if (free) act = ACT_PAD;
        end else if (s_tuser) begin
          if (free) begin
            act   = ACT_PIX;
            start = 1'b1;
          end
        end else if (at_org || discard_q) begin
          if (free) act = ACT_DROP;
        end else if (free) begin
          act = ACT_PIX;
        end
      end
    end
  end

  assign load   = (act == ACT_PIX) || (act == ACT_PAD);
  assign d_data = (act == ACT_PIX) ? s_tdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_line_q <= 1'b0;
      discard_q  <= 1'b0;
    end else begin
      case (act)
        ACT_PIX: begin
          if (line_end) begin
            discard_q <= !s_tlast;
          end else begin
            discard_q <= 1'b0;
            if (s_tlast) pad_line_q <= 1'b1;
          end
        end
        ACT_PAD: begin
          discard_q <= 1'b0;
          if (line_end) pad_line_q <= 1'b0;
        end
        ACT_DROP: begin
          if (s_tlast) discard_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  vfrx_pos #(.DIM_W(DIM_W)) u_pos (
    .clk(clk), .rst(rst), .step(load), .start(start),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .at_org(at_org), .line_end(line_end), .frame_end(frame_end)
  );

  vfrx_oreg #(.W(PIX_W)) u_oreg (
    .clk(clk), .rst(rst), .load(load), .d_data(d_data),
    .d_sof(at_org), .d_eol(line_end), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
    .free(free)
  );
endmodule

// File: rtl/vfrx_frame_rx_chk.sv
module vfrx_frame_rx_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             s_tready,
  input logic             m_valid,
  input logic             m_ready,
  input logic             m_sof,
  input logic             m_eol,
  input logic [PIX_W-1:0] m_data
);
  logic last_eol_q;

  always_ff @(posedge clk) begin
    if (rst) last_eol_q <= 1'b1;
    else if (m_valid && m_ready) last_eol_q <= m_eol;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !m_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol));

  p_block_r9: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |-> !s_tready);

  p_sof_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_ready && m_sof |-> last_eol_q);
endmodule

bind vfrx_frame_rx vfrx_frame_rx_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .s_tready(s_tready), .m_valid(m_valid),
  .m_ready(m_ready), .m_sof(m_sof), .m_eol(m_eol), .m_data(m_data)
);

// File: tb/tb_vfrx_frame_rx.sv
module tb_vfrx_frame_rx;
  localparam int PIX_W = 24;
  localparam int DIM_W = 12;
  localparam int NV = 26;
  localparam int NE = 24;

  // {tuser, tlast, data}
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 24'h000001}, {2'b01, 24'h000002},
    {2'b10, 24'h000010}, {2'b00, 24'h000011}, {2'b01, 24'h000012},
    {2'b00, 24'h000013}, {2'b00, 24'h000014}, {2'b01, 24'h000015},
    {2'b10, 24'hA55A20}, {2'b01, 24'h000021},
    {2'b00, 24'h000022}, {2'b00, 24'h000023}, {2'b00, 24'h000024},
    {2'b00, 24'h000025}, {2'b01, 24'h000026},
    {2'b10, 24'h000030}, {2'b00, 24'h000031}, {2'b01, 24'h000032},
    {2'b10, 24'h000040}, {2'b00, 24'h000041}, {2'b01, 24'h000042},
    {2'b00, 24'h000043}, {2'b00, 24'h000044}, {2'b01, 24'hFF0080},
    {2'b00, 24'h000050}, {2'b01, 24'h000051}
  };
  localparam logic [23:0] EXP [NE] = '{
    24'h000010, 24'h000011, 24'h000012, 24'h000013, 24'h000014, 24'h000015,
    24'hA55A20, 24'h000021, 24'h000000, 24'h000022, 24'h000023, 24'h000024,
    24'h000030, 24'h000031, 24'h000032, 24'h000000, 24'h000000, 24'h000000,
    24'h000040, 24'h000041, 24'h000042, 24'h000043, 24'h000044, 24'hFF0080
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIM_W-1:0] cfg_rows = DIM_W'(2);
  logic [DIM_W-1:0] cfg_cols = DIM_W'(3);
  logic [PIX_W-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tuser = 1'b0;
  logic s_tready;
  logic [PIX_W-1:0] m_data;
  logic m_valid, m_sof, m_eol;
  logic m_ready = 1'b1;

  int checks = 0;
  int fails  = 0;
  int bp_mode = 0;
  int cyc = 0;
  int n_cap = 0;
  logic [23:0] cap_d [64];
  logic        cap_s [64];
  logic        cap_e [64];

  always #10 clk = ~clk;

  vfrx_frame_rx #(.PIX_W(PIX_W), .DIM_W(DIM_W)) dut (
    .clk(clk), .rst(rst), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .s_tuser(s_tuser), .m_data(m_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof), .m_eol(m_eol)
  );

  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      1: m_ready = cyc[0];
      2: m_ready = 1'b0;
      default: m_ready = 1'b1;
    endcase
    if (!rst && m_valid && m_ready && n_cap < 64) begin
      cap_d[n_cap] = m_data;
      cap_s[n_cap] = m_sof;
      cap_e[n_cap] = m_eol;
      n_cap++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic tu, input logic tl, input logic [23:0] d);
    logic ok;
    ok = 1'b0;
    while (!ok) begin
      @(negedge clk);
      s_tvalid = 1'b1; s_tuser = tu; s_tlast = tl; s_tdata = d;
      #1 ok = s_tready;
      @(posedge clk);
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
  endtask

  function automatic string tag_of(input int i);
    if (i < 6)  return "R4";
    if (i == 8) return "R5";
    if (i < 12) return "R6";
    if (i < 18) return "R7";
    return "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(m_valid == 1'b0, "R1 m_valid", 32'(m_valid), 0);
    chk(s_tready == 1'b1, "R1 s_tready", 32'(s_tready), 1);

    // vector table walk
    for (int i = 0; i < NV; i++) send(VEC[i][25], VEC[i][24], VEC[i][23:0]);
    repeat (8) @(negedge clk);
    chk(n_cap == NE, "R2/R3 pixel count", 32'(n_cap), 32'(NE));
    chk(cap_d[0] == 24'h000010, "R2 first pixel after hunt", 32'(cap_d[0]), 32'h10);
    for (int i = 0; i < NE; i++) begin
      chk({cap_d[i], cap_s[i], cap_e[i]} == {EXP[i], (i % 6) == 0, (i % 3) == 2},
          tag_of(i), {6'd0, cap_d[i], cap_s[i], cap_e[i]},
          {6'd0, EXP[i], 1'((i % 6) == 0), 1'((i % 3) == 2)});
    end
    chk(cap_d[6][7:0] == 8'h20 && cap_d[6][15:8] == 8'h5A && cap_d[6][23:16] == 8'hA5,
        "R4 lanes", 32'(cap_d[6]), 32'hA55A20);

    // directed: size change mid-frame with alternating ready
    @(posedge clk);
    n_cap = 0; bp_mode = 1;
    cfg_rows = DIM_W'(1); cfg_cols = DIM_W'(2);
    send(1'b1, 1'b0, 24'h000060);
    cfg_cols = DIM_W'(3);
    send(1'b0, 1'b1, 24'h000061);
    cfg_cols = DIM_W'(2);
    send(1'b1, 1'b1, 24'h000062);
    repeat (10) @(negedge clk);
    chk(n_cap == 4, "R8 count", 32'(n_cap), 4);
    chk({cap_d[1], cap_s[1], cap_e[1]} == {24'h000061, 1'b0, 1'b1}, "R8 line kept at 2",
        {6'd0, cap_d[1], cap_s[1], cap_e[1]}, {6'd0, 24'h000061, 2'b01});
    chk({cap_d[2], cap_s[2]} == {24'h000062, 1'b1}, "R8 next frame start",
        {7'd0, cap_d[2], cap_s[2]}, {7'd0, 24'h000062, 1'b1});
    chk({cap_d[3], cap_e[3]} == {24'h000000, 1'b1}, "R5 pad after short line",
        {7'd0, cap_d[3], cap_e[3]}, {7'd0, 24'h0, 1'b1});

    // directed: stall under held-low ready
    @(posedge clk);
    bp_mode = 2;
    send(1'b1, 1'b0, 24'h000070);
    @(negedge clk);
    s_tvalid = 1'b1; s_tdata = 24'h000071; s_tlast = 1'b1; s_tuser = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(m_valid == 1'b1, "R9 m_valid held", 32'(m_valid), 1);
    chk(s_tready == 1'b0, "R9 s_tready low", 32'(s_tready), 0);
    chk(m_data == 24'h000070, "R9 data held", 32'(m_data), 32'h70);
    @(posedge clk);
    bp_mode = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule